// File: doc/BRIEF.md
# DRAM Refresh Request Timer

This block decides when a DRAM controller must send auto-refresh commands. Memory of this class needs 8192 refresh commands in every 64 ms window, which gives an average spacing of at most 7.8125 µs. Software converts that spacing into memory clock cycles with (64000 × f_MHz) / 8192 (3125 cycles at 400 MHz) and drives the result onto `cfg_interval`. The block counts enabled clock cycles and adds owed refreshes to a pending count. It presents that count to the command arbiter through a request/grant handshake.

Two modes are available. In single mode one refresh is owed every `cfg_interval` cycles. In burst mode the timer runs for eight times that span and then owes eight refreshes at once, so the arbiter can issue them back to back. The average rate is the same in both modes. The timer reloads at each expiry and keeps running while refreshes wait, so a slow arbiter does not lower the long-term refresh rate. The pending count saturates at a fixed ceiling. A sticky flag records that refreshes were lost.

`ref_req` is the valid side of the handshake and `ref_gnt` is the ready side. One refresh is consumed in each cycle where both are high. The arbiter may hold `ref_gnt` low for as long as it needs. The request stays up and the count keeps growing, up to the ceiling. A grant seen while `ref_req` is low has no effect.

Top module: `refresh_sched`

## Requirements
- R1: While `rst_n` is low, `ref_req`, `pend_cnt` and `overflow` are all 0.
- R2: In single mode (`cfg_burst`=0) with a nonzero interval N, the pending count rises by exactly one in the cycle that ends each run of N enabled cycles, counted from the cycle in which enable rises or from the previous expiry.
- R3: In burst mode (`cfg_burst`=1) the timer runs for 8×N enabled cycles and each expiry adds eight to the pending count.
- R4: `ref_req` is 1 exactly when `pend_cnt` is nonzero.
- R5: Each cycle with `ref_req` and `ref_gnt` both 1 lowers the pending count by one. When it coincides with an expiry, the net change is the owed amount minus one. `ref_gnt` has no effect while `ref_req` is 0.
- R6: The interval timer reloads at expiry and keeps counting no matter what `ref_gnt` does. Expiry times therefore depend only on the configuration and on enable.
- R7: The pending count never exceeds MAX_PEND (16 by default). An update that would exceed it leaves the count at MAX_PEND and sets `overflow`. `overflow` then stays 1 until enable drops.
- R8: One cycle with `cfg_enable`=0 clears the timer, the pending count and `overflow`. No refresh is owed while enable stays low.
- R9: While `cfg_interval` is 0 the timer holds and no refresh is ever owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Refresh generation on |
| cfg_burst | input | 1 | 1 selects groups of eight, 0 selects single refreshes |
| cfg_interval | input | IW | Base spacing in clock cycles |
| ref_req | output | 1 | Refresh owed (valid) |
| ref_gnt | input | 1 | Arbiter accepts one refresh (ready) |
| pend_cnt | output | PW | Number of refreshes currently owed |
| overflow | output | 1 | Sticky flag: refreshes were lost to saturation |

## Verification
The assertions assume that `ref_gnt` is a clean synchronous level. They also assume the configuration inputs change only between clock edges, and that a mode or interval change takes effect on the running timer without a restart. The stimulus changes every input half a cycle away from the sampling edge. It moves to a new mode or interval only at phase boundaries, with enable either kept high or deliberately dropped. It also holds `ref_gnt` high while nothing is pending, which exercises the case where a grant must be ignored.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;

  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_BURST  = 1'b1
  } ref_mode_e;

  // Number of refreshes owed by one burst-mode expiry
  localparam int unsigned GROUP_LEN = 8;

endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer
  import refresh_sched_pkg::*;
#(
  parameter int unsigned IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  ref_mode_e     mode,
  input  logic [IW-1:0] interval,
  output logic          expire
);

  localparam int unsigned GW = $clog2(GROUP_LEN);
  localparam int unsigned CW = IW + GW;

  logic [CW-1:0] count_q;
  logic [CW-1:0] period;
  logic          running;

  // Burst mode stretches the period by the group length
  always_comb begin
    if (mode == MODE_BURST)
      period = CW'(interval) * CW'(GROUP_LEN);
    else
      period = CW'(interval);
  end

  assign running = enable && (interval != '0);

  // ">=" so that shortening the interval mid-count still expires promptly
  assign expire = running && (count_q >= (period - CW'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count_q <= '0;
    else if (!running || expire)
      count_q <= '0;
    else
      count_q <= count_q + CW'(1);
  end

endmodule

// File: rtl/refresh_pending_counter.sv
module refresh_pending_counter
  import refresh_sched_pkg::*;
#(
  parameter int unsigned MAX_PEND = 16,
  parameter int unsigned PW       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          expire,
  input  ref_mode_e     mode,
  input  logic          take,
  output logic [PW-1:0] pend,
  output logic          ovf
);

  localparam int unsigned SW = PW + $clog2(GROUP_LEN) + 2;

  logic [SW-1:0] owed;
  logic [SW-1:0] sum;
  logic          too_many;

  always_comb begin
    if (!expire)
      owed = '0;
    else if (mode == MODE_BURST)
      owed = SW'(GROUP_LEN);
    else
      owed = SW'(1);
  end

  // take is only asserted while pend is nonzero, so no underflow
  assign sum      = SW'(pend) + owed - SW'(take);
  assign too_many = sum > SW'(MAX_PEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      ovf  <= 1'b0;
    end else if (!enable) begin
      pend <= '0;
      ovf  <= 1'b0;
    end else if (too_many) begin
      pend <= PW'(MAX_PEND);
      ovf  <= 1'b1;
    end else begin
      pend <= sum[PW-1:0];
    end
  end

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_sched_pkg::*;
#(
  parameter int unsigned IW       = 16,
  parameter int unsigned MAX_PEND = 16,
  parameter int unsigned PW       = $clog2(MAX_PEND + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_enable,
  input  logic          cfg_burst,
  input  logic [IW-1:0] cfg_interval,
  output logic          ref_req,
  input  logic          ref_gnt,
  output logic [PW-1:0] pend_cnt,
  output logic          overflow
);

  ref_mode_e mode;
  logic      expire;
  logic      take;

  assign mode = cfg_burst ? MODE_BURST : MODE_SINGLE;

  refresh_interval_timer #(
    .IW(IW)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (cfg_enable),
    .mode     (mode),
    .interval (cfg_interval),
    .expire   (expire)
  );

  assign ref_req = (pend_cnt != '0);
  assign take    = ref_req && ref_gnt;

  refresh_pending_counter #(
    .MAX_PEND (MAX_PEND),
    .PW       (PW)
  ) u_pending (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (cfg_enable),
    .expire (expire),
    .mode   (mode),
    .take   (take),
    .pend   (pend_cnt),
    .ovf    (overflow)
  );

endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int unsigned IW       = 16,
  parameter int unsigned MAX_PEND = 16,
  parameter int unsigned PW       = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_enable,
  input logic          cfg_burst,
  input logic [IW-1:0] cfg_interval,
  input logic          ref_req,
  input logic          ref_gnt,
  input logic [PW-1:0] pend_cnt,
  input logic          overflow
);

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (!ref_req && !overflow)); // R1

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && !cfg_burst) |=> ({1'b0, pend_cnt} <= ({1'b0, $past(pend_cnt)} + (PW+1)'(1)))); // R2

  AST_HOLD_WITHOUT_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && ref_req && !ref_gnt && !overflow) |=> (pend_cnt >= $past(pend_cnt))); // R5

  AST_PEND_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= PW'(MAX_PEND)); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && cfg_enable) |=> overflow); // R7

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> (!ref_req && !overflow)); // R8

  AST_ZERO_IVL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && (cfg_interval == '0) && !ref_req) |=> !ref_req); // R9

endmodule

bind refresh_sched refresh_sched_chk #(
  .IW(IW), .MAX_PEND(MAX_PEND), .PW(PW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_burst(cfg_burst),
  .cfg_interval(cfg_interval), .ref_req(ref_req), .ref_gnt(ref_gnt),
  .pend_cnt(pend_cnt), .overflow(overflow)
);

// File: tb/refresh_sched_test.sv
`timescale 1ns/1ps
module refresh_sched_test;

  localparam int IW       = 16;
  localparam int MAX_PEND = 16;
  localparam int PW       = $clog2(MAX_PEND + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_enable = 1'b0;
  logic          cfg_burst = 1'b0;
  logic [IW-1:0] cfg_interval = '0;
  logic          ref_gnt = 1'b0;
  logic          ref_req;
  logic [PW-1:0] pend_cnt;
  logic          overflow;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  string cur_req = "R1";

  typedef struct { bit req; int pend; bit ovf; string tag; } exp_t;
  exp_t exp_q[$];

  // model state, built from the requirements
  int m_cnt = 0;
  int m_pend = 0;
  bit m_ovf = 0;

  always #2 clk = ~clk;

  refresh_sched #(.IW(IW), .MAX_PEND(MAX_PEND)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_burst(cfg_burst),
    .cfg_interval(cfg_interval), .ref_req(ref_req), .ref_gnt(ref_gnt),
    .pend_cnt(pend_cnt), .overflow(overflow)
  );

  // Expected-item producer: advances the model at each edge and queues the result
  always @(posedge clk) begin
    exp_t e;
    if (!rst_n || !cfg_enable) begin
      m_cnt = 0; m_pend = 0; m_ovf = 0;
    end else begin
      int per, owed, s;
      bit ex, dec;
      per  = int'(cfg_interval) * (cfg_burst ? 8 : 1);
      ex   = (per != 0) && (m_cnt >= per - 1);
      dec  = ref_gnt && (m_pend != 0);
      owed = ex ? (cfg_burst ? 8 : 1) : 0;
      m_cnt = (per == 0 || ex) ? 0 : m_cnt + 1;
      s = m_pend + owed - (dec ? 1 : 0);
      if (s > MAX_PEND) begin m_pend = MAX_PEND; m_ovf = 1; end
      else m_pend = s;
    end
    e.req = (m_pend != 0); e.pend = m_pend; e.ovf = m_ovf; e.tag = cur_req;
    exp_q.push_back(e);
  end

  // Monitor: compares away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0 && !done) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (int'(pend_cnt) != e.pend) begin
        fails++;
        $display("FAIL %s pend_cnt actual=%0d expected=%0d t=%0t", e.tag, pend_cnt, e.pend, $time);
      end
      checks++;
      if (ref_req != e.req) begin   // R4
        fails++;
        $display("FAIL R4 ref_req actual=%0b expected=%0b t=%0t", ref_req, e.req, $time);
      end
      checks++;
      if (overflow != e.ovf) begin  // R7
        fails++;
        $display("FAIL R7 overflow actual=%0b expected=%0b t=%0t", overflow, e.ovf, $time);
      end
    end
  end

  task automatic run(input string tag, input int n);
    cur_req = tag;
    repeat (n) @(negedge clk);
  endtask

  task automatic toggle_gnt(input string tag, input int n);
    cur_req = tag;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ref_gnt = ~ref_gnt;
    end
  endtask

  task automatic expect_now(input string tag, input int p, input bit o);
    @(negedge clk);
    #0.5;
    checks++;
    if (int'(pend_cnt) != p || overflow != o) begin
      fails++;
      $display("FAIL %s spot pend=%0d/%0b expected=%0d/%0b", tag, pend_cnt, overflow, p, o);
    end
  endtask

  initial begin
    run("R1", 3);
    expect_now("R1", 0, 0);
    rst_n = 1'b1;
    // single mode, no grants: 35 cycles at N=10 gives 3 pending
    cfg_enable = 1; cfg_burst = 0; cfg_interval = 10; ref_gnt = 0;
    run("R2", 35);
    ref_gnt = 1;  run("R5", 12);      // drain, then grant with nothing pending
    ref_gnt = 0;  run("R6", 25);      // timer runs on regardless of grants
    cfg_burst = 1; cfg_interval = 5;  run("R3", 45);
    ref_gnt = 1;  run("R5", 14);
    ref_gnt = 0; cfg_burst = 0; cfg_interval = 2; run("R7", 50);
    expect_now("R7", MAX_PEND, 1);
    cfg_enable = 0; run("R8", 6);
    expect_now("R8", 0, 0);
    cfg_enable = 1; cfg_interval = 0; run("R9", 30);
    expect_now("R9", 0, 0);
    cfg_burst = 1; cfg_interval = 3;  toggle_gnt("R4", 80);
    ref_gnt = 0; run("R4", 3);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule